// File: doc/BRIEF.md
# Linked-List Scatter-Gather DMA Channel

This block is one DMA channel that moves data in a single direction, from one source area to one destination area. It uses one memory-mapped master port. Software writes a chain of four-word descriptors into memory and pulses `start` with the address of the first descriptor. The engine reads a descriptor and moves its elements. It then follows the descriptor's link word to the next descriptor. Because of this, neither side has to be contiguous in memory. Each descriptor sets its own element size, per-side address stepping, per-side byte order, and whether each burst waits for a peripheral request.

The master port has a command channel with valid/ready and a separate response strobe. A command (`m_valid` with `m_addr`, `m_we`, `m_wdata`, `m_be`) stays asserted and unchanged until the cycle in which `m_ready` is high. That cycle transfers it. Only one command is outstanding at any time. The responder completes it by raising `m_rsp_valid` for one cycle, some cycles later. That cycle carries `m_rdata` for reads and `m_rsp_err` for a failure. The engine is always ready for a response while it waits. The peripheral side uses a plain request/acknowledge pair.

Top module: `lldma_engine`

## Requirements
- R1: A `start` pulse while idle takes `first_desc` and raises `busy`. Each descriptor is fetched as four word reads, in this order: source address (+0), destination address (+4), link pointer (+8), control word (+12).
- R2: Control word fields are:
  - bits [15:0]: element count.
  - bits [17:16]: element size, 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. Code 3 acts as 32 bits.
  - bit 18: source increment.
  - bit 19: destination increment.
  - bit 20: source big-endian.
  - bit 21: destination big-endian.
  - bit 22: request-paced mode.
  - bits [31:23]: burst length minus one.
- R3: An incrementing address advances by 1, 2 or 4 bytes after each element. A fixed address keeps its value for the whole descriptor.
- R4: An element occupies the byte lanes of its address: lane k carries bits [8k+7:8k] and the byte at word offset k. A little-endian side keeps the lowest-addressed byte as the least significant. A big-endian side reverses the element's bytes. Writes enable exactly the element's lanes.
- R5: Each element is one read followed by one write. Exactly `count` elements are moved. A count of zero moves nothing and goes straight to the link.
- R6: After the last element, a non-zero link pointer makes the engine fetch the next descriptor from that address. A zero link ends the chain: `busy` falls and `done` rises.
- R7: In request-paced mode, no element read is issued until `dreq` is seen high. Each request moves one burst of up to burst-length elements, or fewer for the final burst. A one-cycle `dack` pulse marks the burst's end. The requester drops `dreq` in the cycle after `dack`. `dreq` is ignored while `dack` is high.
- R8: A command that is not accepted keeps `m_valid`, `m_addr` and `m_we` unchanged in the next cycle. No new command is issued while one is outstanding.
- R9: A response with `m_rsp_err` stops the channel in the next cycle. `error` is set and `busy` falls, and no further commands or descriptor fetches are issued. The next `start` clears `error` and `done`.
- R10: `start` while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `error`, `dack` and `m_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a chain at `first_desc` (idle only) |
| first_desc | input | ADDR_W | Address of the first descriptor |
| dreq | input | 1 | Peripheral burst request |
| dack | output | 1 | One-cycle pulse at the end of a paced burst |
| busy | output | 1 | Channel is running a chain |
| done | output | 1 | Chain ended at a zero link |
| error | output | 1 | Chain stopped by an error response |
| m_valid | output | 1 | Command valid |
| m_ready | input | 1 | Command accepted this cycle |
| m_we | output | 1 | Command is a write |
| m_addr | output | ADDR_W | Command byte address |
| m_wdata | output | 32 | Write data, lane aligned |
| m_be | output | 4 | Byte enables |
| m_rsp_valid | input | 1 | Response strobe for the outstanding command |
| m_rsp_err | input | 1 | Response reports a failure |
| m_rdata | input | 32 | Read data, valid with `m_rsp_valid` |

## Verification
Some properties can be checked in every cycle and are left to the checker:
- command hold under back-pressure and the single-outstanding rule;
- stopping after an error response;
- a quiet master port and a low `dack` whenever the channel is idle;
- the shape of the `dack` pulse;
- write byte enables that cover 1, 2 or 4 lanes.

Other behaviour needs whole scenarios and is shown only by the bench:
- data placement across every size, stepping and byte-order combination;
- the element count and descriptor fetch order;
- link following across a zero-count descriptor;
- burst pacing against `dreq`;
- rejection of a mid-chain `start`.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int DW       = 32;
  localparam int BURST_W  = 9;
  localparam int CNT_W    = 16;

  typedef enum logic [1:0] {EW_8 = 2'd0, EW_16 = 2'd1, EW_32 = 2'd2, EW_32X = 2'd3} ew_e;

  typedef enum logic [1:0] {CK_DESC, CK_READ, CK_WRITE} cmd_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DREQ, S_DRSP, S_ARM, S_WAIT,
    S_RREQ, S_RRSP, S_WREQ, S_WRSP, S_LINK
  } st_e;

  typedef struct packed {
    logic [BURST_W-1:0] burst_m1;
    logic               flow;
    logic               dst_big;
    logic               src_big;
    logic               dst_inc;
    logic               src_inc;
    ew_e                width;
  } xfer_cfg_t;

  function automatic logic [2:0] ew_bytes(ew_e w);
    case (w)
      EW_8:    return 3'd1;
      EW_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DW-1:0] ew_mask(ew_e w);
    case (w)
      EW_8:    return 32'h0000_00FF;
      EW_16:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] ew_lanes(ew_e w);
    case (w)
      EW_8:    return 4'b0001;
      EW_16:   return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [1:0] lane_base(ew_e w, logic [1:0] lo);
    case (w)
      EW_8:    return lo;
      EW_16:   return {lo[1], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [DW-1:0] byte_rev(ew_e w, logic [DW-1:0] v);
    case (w)
      EW_8:    return {24'd0, v[7:0]};
      EW_16:   return {16'd0, v[7:0], v[15:8]};
      default: return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endcase
  endfunction
endpackage

// File: rtl/lldma_unpack.sv
module lldma_unpack
  import lldma_pkg::*;
(
  input  ew_e            width,
  input  logic           big,
  input  logic [1:0]     lo,
  input  logic [DW-1:0]  bus_in,
  output logic [DW-1:0]  elem
);
  logic [1:0]    base;
  logic [DW-1:0] raw;

  always_comb begin
    base = lane_base(width, lo);
    raw  = (bus_in >> {base, 3'b000}) & ew_mask(width);
    elem = big ? byte_rev(width, raw) : raw;
  end
endmodule

// File: rtl/lldma_pack.sv
module lldma_pack
  import lldma_pkg::*;
(
  input  ew_e            width,
  input  logic           big,
  input  logic [1:0]     lo,
  input  logic [DW-1:0]  elem,
  output logic [DW-1:0]  bus_out,
  output logic [3:0]     be
);
  logic [1:0]    base;
  logic [DW-1:0] ordered;

  always_comb begin
    base    = lane_base(width, lo);
    ordered = big ? byte_rev(width, elem & ew_mask(width)) : (elem & ew_mask(width));
    bus_out = ordered << {base, 3'b000};
    be      = 4'(ew_lanes(width) << base);
  end
endmodule

// File: rtl/lldma_desc_regs.sv
module lldma_desc_regs
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [1:0]         load_idx,
  input  logic [DW-1:0]      load_data,
  input  logic               step,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic [ADDR_W-1:0]  next_ptr,
  output ew_e                width,
  output logic               src_big,
  output logic               dst_big,
  output logic               flow,
  output logic [BURST_W-1:0] burst_m1,
  output logic               remain_zero,
  output logic               remain_one
);
  localparam int SIDES = 2;

  xfer_cfg_t          cfg_q;
  logic [CNT_W-1:0]   remain_q;
  logic [ADDR_W-1:0]  next_q;
  logic [ADDR_W-1:0]  side_addr [SIDES];
  logic [SIDES-1:0]   side_inc;
  logic [ADDR_W-1:0]  step_bytes;

  assign side_inc   = {cfg_q.dst_inc, cfg_q.src_inc};
  assign step_bytes = ADDR_W'(ew_bytes(cfg_q.width));

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        side_addr[s] <= '0;
      else if (load_en && load_idx == 2'(s))
        side_addr[s] <= load_data[ADDR_W-1:0];
      else if (step && side_inc[s])
        side_addr[s] <= side_addr[s] + step_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q   <= '0;
      cfg_q    <= '0;
      remain_q <= '0;
    end else if (load_en && load_idx == 2'd2) begin
      next_q <= load_data[ADDR_W-1:0];
    end else if (load_en && load_idx == 2'd3) begin
      remain_q       <= load_data[15:0];
      cfg_q.width    <= ew_e'(load_data[17:16]);
      cfg_q.src_inc  <= load_data[18];
      cfg_q.dst_inc  <= load_data[19];
      cfg_q.src_big  <= load_data[20];
      cfg_q.dst_big  <= load_data[21];
      cfg_q.flow     <= load_data[22];
      cfg_q.burst_m1 <= load_data[31:23];
    end else if (step) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign src_addr    = side_addr[0];
  assign dst_addr    = side_addr[1];
  assign next_ptr    = next_q;
  assign width       = cfg_q.width;
  assign src_big     = cfg_q.src_big;
  assign dst_big     = cfg_q.dst_big;
  assign flow        = cfg_q.flow;
  assign burst_m1    = cfg_q.burst_m1;
  assign remain_zero = (remain_q == '0);
  assign remain_one  = (remain_q == CNT_W'(1));
endmodule

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  first_desc,
  input  logic               dreq,
  input  logic               m_ready,
  input  logic               m_rsp_valid,
  input  logic               m_rsp_err,
  input  logic [ADDR_W-1:0]  next_ptr,
  input  logic               flow,
  input  logic [BURST_W-1:0] burst_m1,
  input  logic               remain_zero,
  input  logic               remain_one,
  output logic               cmd_valid,
  output cmd_kind_e          cmd_kind,
  output logic [ADDR_W-1:0]  desc_addr,
  output logic               load_en,
  output logic [1:0]         load_idx,
  output logic               step,
  output logic               latch_rd,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic               dack
);
  st_e                st_q;
  logic [1:0]         idx_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic [BURST_W-1:0] burst_q;
  logic               done_q, err_q, dack_q;
  logic               rsp_ok, rsp_bad;

  always_comb begin
    rsp_ok    = m_rsp_valid && !m_rsp_err;
    rsp_bad   = m_rsp_valid &&  m_rsp_err;
    cmd_valid = (st_q == S_DREQ) || (st_q == S_RREQ) || (st_q == S_WREQ);
    cmd_kind  = (st_q == S_RREQ) ? CK_READ : (st_q == S_WREQ) ? CK_WRITE : CK_DESC;
    desc_addr = ptr_q + ADDR_W'({idx_q, 2'b00});
    load_en   = (st_q == S_DRSP) && rsp_ok;
    load_idx  = idx_q;
    step      = (st_q == S_WRSP) && rsp_ok;
    latch_rd  = (st_q == S_RRSP) && rsp_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      burst_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      dack_q  <= 1'b0;
    end else begin
      dack_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          ptr_q  <= first_desc;
          idx_q  <= '0;
          done_q <= 1'b0;
          err_q  <= 1'b0;
          st_q   <= S_DREQ;
        end
        S_DREQ: if (m_ready) st_q <= S_DRSP;
        S_DRSP: begin
          if (rsp_bad) begin
            err_q <= 1'b1;
            st_q  <= S_IDLE;
          end else if (rsp_ok) begin
            if (idx_q == 2'd3) st_q <= S_ARM;
            else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= S_DREQ;
            end
          end
        end
        S_ARM: begin
          burst_q <= burst_m1;
          if (remain_zero) st_q <= S_LINK;
          else if (flow)   st_q <= S_WAIT;
          else             st_q <= S_RREQ;
        end
        S_WAIT: if (dreq && !dack_q) begin
          burst_q <= burst_m1;
          st_q    <= S_RREQ;
        end
        S_RREQ: if (m_ready) st_q <= S_RRSP;
        S_RRSP: begin
          if (rsp_bad) begin
            err_q <= 1'b1;
            st_q  <= S_IDLE;
          end else if (rsp_ok) st_q <= S_WREQ;
        end
        S_WREQ: if (m_ready) st_q <= S_WRSP;
        S_WRSP: begin
          if (rsp_bad) begin
            err_q <= 1'b1;
            st_q  <= S_IDLE;
          end else if (rsp_ok) begin
            if (remain_one) begin
              dack_q <= flow;
              st_q   <= S_LINK;
            end else if (flow && burst_q == '0) begin
              dack_q <= 1'b1;
              st_q   <= S_WAIT;
            end else begin
              if (burst_q != '0) burst_q <= burst_q - 1'b1;
              st_q <= S_RREQ;
            end
          end
        end
        S_LINK: begin
          if (next_ptr == '0) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            ptr_q <= next_ptr;
            idx_q <= '0;
            st_q  <= S_DREQ;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy  = (st_q != S_IDLE);
  assign done  = done_q;
  assign error = err_q;
  assign dack  = dack_q;
endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_desc,
  input  logic              dreq,
  output logic              dack,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DW-1:0]     m_wdata,
  output logic [3:0]        m_be,
  input  logic              m_rsp_valid,
  input  logic              m_rsp_err,
  input  logic [DW-1:0]     m_rdata
);
  logic               load_en, step, latch_rd;
  logic [1:0]         load_idx;
  logic [ADDR_W-1:0]  src_addr, dst_addr, next_ptr, desc_addr;
  ew_e                width;
  logic               src_big, dst_big, flow, remain_zero, remain_one;
  logic [BURST_W-1:0] burst_m1;
  cmd_kind_e          cmd_kind;
  logic               cmd_valid;
  logic [DW-1:0]      rd_elem, elem_q, wr_bus;
  logic [3:0]         wr_be;

  lldma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .first_desc(first_desc), .dreq(dreq),
    .m_ready(m_ready), .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err),
    .next_ptr(next_ptr), .flow(flow), .burst_m1(burst_m1),
    .remain_zero(remain_zero), .remain_one(remain_one),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .desc_addr(desc_addr),
    .load_en(load_en), .load_idx(load_idx), .step(step), .latch_rd(latch_rd),
    .busy(busy), .done(done), .error(error), .dack(dack)
  );

  lldma_desc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .load_data(m_rdata), .step(step),
    .src_addr(src_addr), .dst_addr(dst_addr), .next_ptr(next_ptr),
    .width(width), .src_big(src_big), .dst_big(dst_big), .flow(flow),
    .burst_m1(burst_m1), .remain_zero(remain_zero), .remain_one(remain_one)
  );

  lldma_unpack u_unpack (
    .width(width), .big(src_big), .lo(src_addr[1:0]), .bus_in(m_rdata), .elem(rd_elem)
  );

  lldma_pack u_pack (
    .width(width), .big(dst_big), .lo(dst_addr[1:0]), .elem(elem_q),
    .bus_out(wr_bus), .be(wr_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        elem_q <= '0;
    else if (latch_rd) elem_q <= rd_elem;
  end

  always_comb begin
    m_valid = cmd_valid;
    m_we    = (cmd_kind == CK_WRITE);
    m_wdata = wr_bus;
    case (cmd_kind)
      CK_READ:  begin m_addr = src_addr;  m_be = 4'hF;  end
      CK_WRITE: begin m_addr = dst_addr;  m_be = wr_be; end
      default:  begin m_addr = desc_addr; m_be = 4'hF;  end
    endcase
  end
endmodule

// File: rtl/lldma_checker.sv
module lldma_checker #(
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_we,
  input logic [ADDR_W-1:0] m_addr,
  input logic [3:0]        m_be,
  input logic              m_rsp_valid,
  input logic              m_rsp_err,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              dack
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   outstanding <= 1'b0;
    else if (m_valid && m_ready)  outstanding <= 1'b1;
    else if (m_rsp_valid)         outstanding <= 1'b0;
  end

  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_we));

  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(outstanding && m_valid));

  a_r9_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_valid && m_rsp_err && outstanding |=> error && !busy);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_valid && !dack);

  a_r6_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !error);

  a_r7_dack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> !dack);

  a_r4_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_we |-> ($countones(m_be) == 1) || ($countones(m_be) == 2) || ($countones(m_be) == 4));
endmodule

bind lldma_engine lldma_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_we(m_we),
  .m_addr(m_addr), .m_be(m_be), .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err),
  .busy(busy), .done(done), .error(error), .dack(dack)
);

// File: tb/sim_lldma_engine.sv
module sim_lldma_engine;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, dreq, dack, busy, done, error;
  logic [31:0] first_desc;
  logic        m_valid, m_ready, m_we, m_rsp_valid, m_rsp_err;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [3:0]  m_be;

  lldma_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .first_desc(first_desc), .dreq(dreq),
    .dack(dack), .busy(busy), .done(done), .error(error),
    .m_valid(m_valid), .m_ready(m_ready), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_be(m_be), .m_rsp_valid(m_rsp_valid),
    .m_rsp_err(m_rsp_err), .m_rdata(m_rdata)
  );

  logic [7:0]  mem [0:4095];
  logic [7:0]  expm [0:4095];
  logic [31:0] tlog [0:63];
  int checks = 0, fails = 0, txn = 0, cyc = 0, hold_viol = 0;
  bit fast_rdy = 0;
  logic acc_pend = 0, acc_we = 0, prev_stall = 0;
  logic [31:0] acc_addr = 0, acc_wdata = 0, prev_addr = 0;
  logic [3:0]  acc_be = 0;

  // memory responder: drives at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (prev_stall && (!m_valid || m_addr != prev_addr)) hold_viol++;
    m_rsp_valid = 1'b0;
    m_rsp_err   = 1'b0;
    m_rdata     = 32'd0;
    if (acc_pend) begin
      acc_pend    = 1'b0;
      m_rsp_valid = 1'b1;
      if (acc_addr >= 32'h1000) m_rsp_err = 1'b1;
      else begin
        for (int k = 0; k < 4; k++) begin
          if (acc_we) begin
            if (acc_be[k]) mem[(acc_addr & 32'hFFC) + k] = acc_wdata[8*k +: 8];
          end else m_rdata[8*k +: 8] = mem[(acc_addr & 32'hFFC) + k];
        end
      end
    end
    m_ready = fast_rdy || (cyc % 3 != 1);
    if (rst_n && m_valid && m_ready) begin
      acc_pend  = 1'b1;
      acc_addr  = m_addr;
      acc_we    = m_we;
      acc_wdata = m_wdata;
      acc_be    = m_be;
      tlog[txn % 64] = m_addr;
      txn++;
    end
    prev_stall = rst_n && m_valid && !m_ready;
    prev_addr  = m_addr;
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exv);
    end
  endtask

  function automatic logic [31:0] ctl(int cnt, int w, int si, int di, int sb, int db, int fl, int bm1);
    return 32'(cnt) | (32'(w) << 16) | (32'(si) << 18) | (32'(di) << 19) |
           (32'(sb) << 20) | (32'(db) << 21) | (32'(fl) << 22) | (32'(bm1) << 23);
  endfunction

  task automatic put_word(int a, logic [31:0] v);
    for (int k = 0; k < 4; k++) begin
      mem[a+k]  = v[8*k +: 8];
      expm[a+k] = v[8*k +: 8];
    end
  endtask

  task automatic put_desc(int p, int s, int d, int nx, logic [31:0] c);
    put_word(p, 32'(s)); put_word(p+4, 32'(d)); put_word(p+8, 32'(nx)); put_word(p+12, c);
  endtask

  // arithmetic reference of one descriptor, applied to expm
  task automatic model(int s, int d, int cnt, int w, int si, int di, int sb, int db);
    int sz;
    sz = 1 << w;
    for (int i = 0; i < cnt; i++) begin
      int sa, da;
      logic [31:0] v;
      sa = s + (si != 0 ? i*sz : 0);
      da = d + (di != 0 ? i*sz : 0);
      v = 0;
      for (int k = 0; k < sz; k++)
        v = v | (32'(expm[sa+k]) << (8 * (sb != 0 ? sz-1-k : k)));
      for (int k = 0; k < sz; k++)
        expm[da+k] = 8'(v >> (8 * (db != 0 ? sz-1-k : k)));
    end
  endtask

  task automatic cmp_mem(string req, string what);
    int bad;
    bad = -1;
    for (int a = 0; a < 4096; a++) if (bad < 0 && mem[a] !== expm[a]) bad = a;
    if (bad < 0) chk(1, req, what, 0, 0);
    else chk(0, req, {what, " byte"}, {bad[15:0], 8'h00, mem[bad]}, {bad[15:0], 8'h00, expm[bad]});
  endtask

  task automatic pulse_start(int p);
    start = 1'b1; first_desc = 32'(p);
    tick();
    start = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n;
    n = 0;
    while (busy && n < 20000) begin tick(); n++; end
    chk(!busy, req, "channel returned to idle", 32'(busy), 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; start = 1'b0; dreq = 1'b0; first_desc = 0;
    for (int a = 0; a < 4096; a++) begin
      mem[a]  = 8'((a * 13 + 7) & 255);
      expm[a] = mem[a];
    end
    tick(); tick();
    // R11 reset state
    chk(!busy && !done && !error, "R11", "status low in reset", {busy, done, error}, 0);
    chk(!m_valid && !dack, "R11", "port quiet in reset", {m_valid, dack}, 0);
    rst_n = 1'b1;
    tick();
    chk(!busy && !m_valid, "R11", "idle after reset", {busy, m_valid}, 0);

    // Sweep: size x stepping x byte order, with lane offsets (R2 R3 R4 R5)
    for (int idx = 0; idx < 48; idx++) begin
      int w, si, di, sb, db, cnt, off, off2, s, d;
      w = idx % 3; si = (idx/3) % 2; di = (idx/6) % 2; sb = (idx/12) % 2; db = (idx/24) % 2;
      cnt  = 1 + idx % 5;
      off  = (w == 0) ? idx % 4 : (w == 1) ? 2*(idx % 2) : 0;
      off2 = (w == 0) ? (idx/2) % 4 : (w == 1) ? 2*((idx/2) % 2) : 0;
      s = 'h100 + 16*(idx % 8) + off;
      d = 'h400 + 32*(idx % 4) + off2;
      fast_rdy = (idx % 2) == 1;
      put_desc('h800, s, d, 0, ctl(cnt, w, si, di, sb, db, 0, 0));
      model(s, d, cnt, w, si, di, sb, db);
      base = txn;
      pulse_start('h800);
      wait_idle("R1");
      chk(done && !error, "R6", "zero link sets done", {done, error}, 32'h2);
      chk(txn - base == 4 + 2*cnt, "R5", "one read and one write per element",
          32'(txn - base), 32'(4 + 2*cnt));
      cmp_mem("R2 R3 R4", "destination contents");
      if (idx == 0)
        for (int k = 0; k < 4; k++)
          chk(tlog[(base + k) % 64] == 32'('h800 + 4*k), "R1", "descriptor word order",
              tlog[(base + k) % 64], 32'('h800 + 4*k));
    end
    fast_rdy = 0;

    // Chain with a zero-count middle descriptor (R5 R6)
    put_desc('h800, 'h104, 'h500, 'h840, ctl(3, 2, 1, 1, 0, 0, 0, 0));
    put_desc('h840, 'h1F0, 'h5F0, 'h880, ctl(0, 0, 1, 1, 0, 0, 0, 0));
    put_desc('h880, 'h203, 'h601, 0,      ctl(4, 0, 1, 1, 0, 1, 0, 0));
    model('h104, 'h500, 3, 2, 1, 1, 0, 0);
    model('h203, 'h601, 4, 0, 1, 1, 0, 1);
    base = txn;
    pulse_start('h800);
    wait_idle("R6");
    chk(txn - base == 26, "R5", "zero count moves nothing", 32'(txn - base), 26);
    chk(tlog[(base + 10) % 64] == 32'h840, "R6", "link fetch address", tlog[(base + 10) % 64], 32'h840);
    chk(tlog[(base + 14) % 64] == 32'h880, "R6", "second link fetch", tlog[(base + 14) % 64], 32'h880);
    chk(done && !error, "R6", "chain done", {done, error}, 32'h2);
    cmp_mem("R6", "chained contents");

    // Request-paced bursts of 3 over 7 elements (R7), start while busy (R10)
    put_desc('h900, 'h120, 'h700, 0, ctl(7, 1, 1, 1, 0, 0, 1, 2));
    model('h120, 'h700, 7, 1, 1, 1, 0, 0);
    base = txn;
    pulse_start('h900);
    for (int n = 0; n < 40; n++) tick();
    chk(busy && txn - base == 4, "R7", "no element read before request", 32'(txn - base), 4);
    pulse_start('h800);
    for (int n = 0; n < 10; n++) tick();
    chk(txn - base == 4, "R10", "start while busy ignored", 32'(txn - base), 4);
    for (int b = 0; b < 3; b++) begin
      int n, moved;
      moved = (b < 2) ? 3*(b+1) : 7;
      dreq = 1'b1;
      n = 0;
      while (!dack && n < 500) begin tick(); n++; end
      dreq = 1'b0;
      chk(dack, "R7", "dack at burst end", 32'(dack), 1);
      chk(txn - base == 4 + 2*moved, "R7", "elements per burst", 32'(txn - base), 32'(4 + 2*moved));
      tick();
      chk(!dack, "R7", "dack lasts one cycle", 32'(dack), 0);
      for (int q = 0; q < 8; q++) tick();
      chk(txn - base == 4 + 2*moved, "R7", "idle between requests", 32'(txn - base), 32'(4 + 2*moved));
    end
    wait_idle("R7");
    chk(done, "R7", "paced chain done", 32'(done), 1);
    cmp_mem("R7 R10", "paced contents");

    // Error on element read (R9)
    put_desc('h980, 'h1000, 'h700, 'h800, ctl(2, 2, 1, 1, 0, 0, 0, 0));
    base = txn;
    pulse_start('h980);
    wait_idle("R9");
    chk(error && !done, "R9", "error flag set", {error, done}, 32'h2);
    for (int n = 0; n < 20; n++) tick();
    chk(txn - base == 5, "R9", "no commands after error", 32'(txn - base), 5);
    // Error on descriptor fetch
    base = txn;
    pulse_start('h2000);
    wait_idle("R9");
    chk(error && txn - base == 1, "R9", "fetch error stops", 32'(txn - base), 1);
    // Restart clears the error flag
    put_desc('h800, 'h100, 'h480, 0, ctl(2, 2, 1, 1, 1, 0, 0, 0));
    model('h100, 'h480, 2, 2, 1, 1, 1, 0);
    pulse_start('h800);
    chk(!error, "R9", "start clears error", 32'(error), 0);
    wait_idle("R9");
    chk(done && !error, "R9", "good run after error", {done, error}, 32'h2);
    cmp_mem("R9", "post-error contents");

    chk(hold_viol == 0, "R8", "command held under back-pressure", 32'(hold_viol), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule